// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block conditions 24 digital input lines before the rest of the chip samples them. Every line passes through a two-flop synchronizer. A line whose filter bit is clear then reaches its output one register later. A line whose filter bit is set changes its output only once the synchronized input has held a new level for a programmable stability interval. Pulses shorter than that interval never reach the output.

The interval is one 20-bit value shared by all lines. It counts ticks of a fixed 200 ns period, and a prescaler derives that tick from the system clock. Software reaches the block through a byte-wide register port with an address, a write strobe, write data and combinational read data. The port holds the interval bytes, the filter-enable bytes and a command byte, and it returns the synchronized input levels on read. The command byte carries two self-clearing actions: one zeroes the interval and restarts the prescaler, and the other resynchronizes every filtered output with its input.

Each line is driven by a two-state machine. In state STABLE the output equals the input. When a filtered line sees a mismatch and the interval is nonzero, the transition QUALIFY-ENTER moves it to QUALIFY and its tick counter starts from zero. From QUALIFY, transition DROP goes back to STABLE when the input returns to the output level, and transition ACCEPT goes back to STABLE on the tick that brings the counter to the interval, loading the new level. Transition FORCE goes to STABLE from either state when the line is unfiltered, when the interval is zero, or when a filter clear is commanded.

Top module: `dglitch_filter`

## Requirements
- R1: After reset, `dout` is all zeros and every interval and enable byte reads 0, so all lines are unfiltered.
- R2: A line whose enable bit is 0 shows on `dout` the value that `din` had three clock edges earlier (two synchronizer flops plus the output register).
- R3: A filtered line with interval N >= 1 presents a new input level on `dout` no later than N*TICK + 3 clock edges after the level appears on `din`. Its output changes only on a tick, a filter clear, or while the interval is 0.
- R4: A filtered line with interval N >= 2 ignores any pulse that lasts fewer than (N-1)*TICK clock cycles, and it shows no change within (N-1)*TICK + 3 edges of a held change.
- R5: With the interval equal to 0, a filtered line has exactly the timing of an unfiltered line.
- R6: Interval bits 7:0 are written at address 0x08, bits 15:8 at 0x09, and bits 19:16 at 0x0A from the low nibble. The high nibble at 0x0A is ignored and reads 0. All three bytes read back.
- R7: The enable mask is written and read at 0x0C, 0x0D and 0x0E for lines 0-7, 8-15 and 16-23. Bit n of the mask controls line n, and 1 means filtered.
- R8: Writing address 0x07 with bit 0 set zeroes the interval and restarts the tick prescaler. Address 0x07 always reads 0.
- R9: Writing address 0x07 with bit 1 set loads every filtered output with its synchronized input within two edges and zeroes all stability counters.
- R10: Addresses 0x00, 0x01 and 0x02 read the synchronized input levels of lines 0-7, 8-15 and 16-23.
- R11: A tick occurs once every TICK = CLK_HZ / 5,000,000 clock cycles, which is 200 ns, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| din | input | 24 | Raw asynchronous input lines |
| dout | output | 24 | Conditioned input lines |

## Verification
The hardest case to reach from the ports is the mixture of held edges and short glitches that cross tick boundaries on filtered lines, while the neighbouring unfiltered lines must follow the same glitches. Random rounds choose an interval of 2 to 6 ticks, a random enable mask, a random set of stepping lines and a disjoint random set of glitching lines. The glitch length is (N-1)*TICK-5 cycles, just short of the suppression limit. The outputs are checked part-way through the glitch and again after N+1 ticks. Directed cases fix the early and late timing bounds at one interval, and a near-maximal interval holds a mismatch pending so that the filter-clear command can be seen to take effect.

// File: rtl/dgf_pkg.sv
`timescale 1ns/1ps
package dgf_pkg;
    localparam int TICK_HZ  = 5_000_000;   // 200 ns tick rate
    localparam int A_RAW0   = 'h00;
    localparam int A_CMD    = 'h07;
    localparam int A_IVL0   = 'h08;
    localparam int A_EN0    = 'h0C;
    localparam int CMD_CLR_IVL  = 0;
    localparam int CMD_CLR_FILT = 1;

    typedef enum logic {
        CH_STABLE  = 1'b0,
        CH_QUALIFY = 1'b1
    } ch_state_t;
endpackage

// File: rtl/dgf_sync.sv
`timescale 1ns/1ps
module dgf_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dgf_tick.sv
`timescale 1ns/1ps
module dgf_tick #(
    parameter int CLK_HZ = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    import dgf_pkg::*;
    localparam int TICK_CYC = CLK_HZ / TICK_HZ;
    localparam int CW       = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(TICK_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dgf_regs.sv
`timescale 1ns/1ps
module dgf_regs #(
    parameter int NCH    = 24,
    parameter int IVL_W  = 20,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [NCH-1:0]    raw,
    output logic [7:0]        rdata,
    output logic [IVL_W-1:0]  ivl,
    output logic [NCH-1:0]    en,
    output logic              clr_ivl,
    output logic              clr_filt
);
    import dgf_pkg::*;
    localparam int IVL_B = (IVL_W + 7) / 8;
    localparam int EN_B  = (NCH + 7) / 8;
    localparam logic [IVL_B*8-1:0] IVL_MASK = {(IVL_B*8){1'b1}} >> (IVL_B*8 - IVL_W);
    localparam logic [EN_B*8-1:0]  EN_MASK  = {(EN_B*8){1'b1}} >> (EN_B*8 - NCH);

    logic [IVL_B*8-1:0] ivl_pad;
    logic [EN_B*8-1:0]  en_pad;
    logic [EN_B*8-1:0]  raw_pad;
    logic               cmd_wr;

    assign cmd_wr = we && (addr == ADDR_W'(A_CMD));
    assign ivl    = ivl_pad[IVL_W-1:0];
    assign en     = en_pad[NCH-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_pad  <= '0;
            en_pad   <= '0;
            clr_ivl  <= 1'b0;
            clr_filt <= 1'b0;
        end else begin
            clr_ivl  <= cmd_wr && wdata[CMD_CLR_IVL];
            clr_filt <= cmd_wr && wdata[CMD_CLR_FILT];
            for (int b = 0; b < IVL_B; b++)
                if (we && addr == ADDR_W'(A_IVL0 + b))
                    ivl_pad[b*8 +: 8] <= wdata & IVL_MASK[b*8 +: 8];
            for (int b = 0; b < EN_B; b++)
                if (we && addr == ADDR_W'(A_EN0 + b))
                    en_pad[b*8 +: 8] <= wdata & EN_MASK[b*8 +: 8];
            if (cmd_wr && wdata[CMD_CLR_IVL])
                ivl_pad <= '0;
        end
    end

    always_comb begin
        raw_pad          = '0;
        raw_pad[NCH-1:0] = raw;
        rdata            = 8'h00;
        for (int b = 0; b < EN_B; b++) begin
            if (addr == ADDR_W'(A_RAW0 + b)) rdata = raw_pad[b*8 +: 8];
            if (addr == ADDR_W'(A_EN0 + b))  rdata = en_pad[b*8 +: 8];
        end
        for (int b = 0; b < IVL_B; b++)
            if (addr == ADDR_W'(A_IVL0 + b)) rdata = ivl_pad[b*8 +: 8];
    end
endmodule

// File: rtl/dgf_chan.sv
`timescale 1ns/1ps
module dgf_chan #(
    parameter int IVL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  logic             en,
    input  logic             tick,
    input  logic             clr,
    input  logic [IVL_W-1:0] ivl,
    output logic             q
);
    import dgf_pkg::*;

    ch_state_t        st, st_nx;
    logic [IVL_W-1:0] cnt;
    logic             mismatch, ivl_zero, force_stable, done;

    assign mismatch     = d ^ q;
    assign ivl_zero     = (ivl == '0);
    assign force_stable = clr || !en || ivl_zero;
    assign done         = tick && (({1'b0, cnt} + {{IVL_W{1'b0}}, 1'b1}) >= {1'b0, ivl});

    // next-state: QUALIFY-ENTER, DROP, ACCEPT, FORCE
    always_comb begin
        st_nx = st;
        if (force_stable) begin
            st_nx = CH_STABLE;
        end else begin
            unique case (st)
                CH_STABLE:  if (mismatch)          st_nx = CH_QUALIFY;
                CH_QUALIFY: if (!mismatch || done) st_nx = CH_STABLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_STABLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
        end else begin
            if (force_stable)
                q <= d;
            else if (st == CH_QUALIFY && mismatch && done)
                q <= d;
            if (st == CH_QUALIFY && st_nx == CH_QUALIFY) begin
                if (tick) cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/dglitch_filter.sv
`timescale 1ns/1ps
module dglitch_filter #(
    parameter int CLK_HZ = 200_000_000,
    parameter int NCH    = 24,
    parameter int IVL_W  = 20,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NCH-1:0]    din,
    output logic [NCH-1:0]    dout
);
    logic [NCH-1:0]   sync_q;
    logic [NCH-1:0]   filt_en;
    logic [IVL_W-1:0] ivl;
    logic             tick, clr_ivl, clr_filt;

    dgf_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(sync_q)
    );

    dgf_regs #(.NCH(NCH), .IVL_W(IVL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .raw(sync_q), .rdata(reg_rdata),
        .ivl(ivl), .en(filt_en), .clr_ivl(clr_ivl), .clr_filt(clr_filt)
    );

    dgf_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(clr_ivl), .tick(tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dgf_chan #(.IVL_W(IVL_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .d(sync_q[c]), .en(filt_en[c]),
            .tick(tick), .clr(clr_filt), .ivl(ivl), .q(dout[c])
        );
    end
endmodule

// File: rtl/dgf_checker.sv
`timescale 1ns/1ps
module dgf_checker #(
    parameter int NCH    = 24,
    parameter int IVL_W  = 20,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    dout,
    input logic [NCH-1:0]    s2,
    input logic [NCH-1:0]    en,
    input logic [IVL_W-1:0]  ivl,
    input logic              tick,
    input logic              clr_filt,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata
);
    AST_UNFILT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout ^ $past(s2)) & ~$past(en)) == '0); // R2
    AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (((dout ^ $past(dout)) & $past(en)) != '0) |->
        ($past(tick) || $past(clr_filt) || ($past(ivl) == '0))); // R3
    AST_IVL_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ivl) == '0) |-> (dout == $past(s2))); // R5
    AST_CLR_FILT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_filt) |-> (dout == $past(s2))); // R9
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(7)) |-> (reg_rdata == 8'h00)); // R8
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11
endmodule

bind dglitch_filter dgf_checker #(.NCH(NCH), .IVL_W(IVL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dout(dout), .s2(sync_q), .en(filt_en),
    .ivl(ivl), .tick(tick), .clr_filt(clr_filt),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_dglitch_filter.sv
`timescale 1ns/1ps
module sim_dglitch_filter;
    localparam int TICK = 40;   // 200 ns at 200 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [23:0] din = '0;
    logic [23:0] dout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_f = 1'b0;

    always #2.5 clk = ~clk;

    dglitch_filter u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din(din), .dout(dout)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done_f) begin
            done_f = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog got %0d cycles exp below 150000", cyc);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic set_ivl(logic [19:0] n);
        wr(5'h08, n[7:0]); wr(5'h09, n[15:8]); wr(5'h0A, {4'h0, n[19:16]});
    endtask

    task automatic set_en(logic [23:0] m);
        wr(5'h0C, m[7:0]); wr(5'h0D, m[15:8]); wr(5'h0E, m[23:16]);
    endtask

    function automatic logic [23:0] exp_early(logic [23:0] old, logic [23:0] chg, logic [23:0] en);
        return old ^ (chg & ~en);   // only unfiltered lines move early
    endfunction

    initial begin
        logic [23:0] m, old, step, glit;
        int n;
        void'($urandom(32'd1234));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk("R1 dout", {8'h0, dout}, 32'h0);
        for (int a = 8; a <= 14; a++) if (a != 11) rd_chk("R1 reg", 5'(a), 8'h00);

        // R2 / R10 unfiltered pass-through and raw readback
        din = 24'hA5C33C;
        wait_n(2);
        chk("R2 not before 3 edges", {8'h0, dout}, 32'h0);
        wait_n(1);
        chk("R2 dout follows", {8'h0, dout}, {8'h0, din});
        rd_chk("R10 byte0", 5'h00, 8'h3C);
        rd_chk("R10 byte1", 5'h01, 8'hC3);
        rd_chk("R10 byte2", 5'h02, 8'hA5);

        // R6 interval bytes, high nibble dropped
        wr(5'h08, 8'h34); wr(5'h09, 8'h12); wr(5'h0A, 8'hF5);
        rd_chk("R6 ivl lo", 5'h08, 8'h34);
        rd_chk("R6 ivl mid", 5'h09, 8'h12);
        rd_chk("R6 ivl hi nibble", 5'h0A, 8'h05);

        // R8 clear interval command
        wr(5'h07, 8'h01);
        rd_chk("R8 ivl0 cleared", 5'h08, 8'h00);
        rd_chk("R8 ivl1 cleared", 5'h09, 8'h00);
        rd_chk("R8 ivl2 cleared", 5'h0A, 8'h00);
        rd_chk("R8 cmd reads zero", 5'h07, 8'h00);

        // R7 enable mask readback
        m = 24'($urandom);
        set_en(m);
        rd_chk("R7 en0", 5'h0C, m[7:0]);
        rd_chk("R7 en1", 5'h0D, m[15:8]);
        rd_chk("R7 en2", 5'h0E, m[23:16]);

        // R5 interval zero behaves unfiltered
        set_en(24'hFFFFFF);
        old = dout;
        din = 24'($urandom);
        wait_n(2);
        chk("R5 not before 3 edges", {8'h0, dout}, {8'h0, old});
        wait_n(1);
        chk("R5 ivl zero passes", {8'h0, dout}, {8'h0, din});

        // R11 timing bounds with interval 3 on line 4
        set_en(24'h000010);
        set_ivl(20'd3);
        wr(5'h07, 8'h02);
        wait_n(4);
        old = dout;
        din = din ^ 24'h000010;
        wait_n(2 * TICK + 3);
        chk("R11 R4 early bound", {8'h0, dout}, {8'h0, old ^ ((24'h000010 ^ 24'hFFFFFF) & (old ^ din))});
        wait_n(TICK);
        chk("R11 R3 late bound", {8'h0, dout}, {8'h0, din});

        // R3 / R4 random rounds
        for (int r = 0; r < 20; r++) begin
            n = 2 + int'($urandom % 5);
            m = 24'($urandom);
            set_ivl(20'(n));
            set_en(m);
            wr(5'h07, 8'h02);
            wait_n(4);
            old = din;
            chk("R9 aligned before round", {8'h0, dout}, {8'h0, old});
            step = 24'($urandom);
            glit = 24'($urandom) & ~step;
            din = old ^ step ^ glit;
            wait_n(8);
            chk("R4 R2 mid glitch", {8'h0, dout}, {8'h0, exp_early(old, step | glit, m)});
            wait_n((n - 1) * TICK - 5 - 8);
            din = old ^ step;
            wait_n((n + 1) * TICK + 10);
            chk("R3 R4 settled", {8'h0, dout}, {8'h0, old ^ step});
        end

        // R9 clear filter releases a pending change
        set_en(24'hFFFFFF);
        set_ivl(20'hFFFFF);
        wr(5'h07, 8'h02);
        wait_n(4);
        old = dout;
        din = ~din;
        wait_n(100);
        chk("R3 long interval holds", {8'h0, dout}, {8'h0, old});
        wr(5'h07, 8'h02);
        wait_n(2);
        chk("R9 clear loads input", {8'h0, dout}, {8'h0, din});
        rd_chk("R9 cmd reads zero", 5'h07, 8'h00);
        rd_chk("R9 ivl kept", 5'h0A, 8'h0F);

        done_f = 1'b1;
        summary();
    end
endmodule